// File: doc/BRIEF.md
# Phase-Shifted Multilevel PWM Generator

This block drives the gates of one leg of a five-level flying-capacitor converter. The leg has four switch cells. Each cell has a main switch and a complementary switch, so the block drives eight gates. All four cells use one shared duty word. Each cell has its own triangle-free sawtooth carrier. The four carriers are spread evenly over one carrier period. As a result, the switch node steps through five levels, each one quarter of the input voltage. The node switches at four times the carrier frequency.

Software or a modulator sets the carrier period in clock cycles, the duty word and a dead-time count. A single-cycle synchronous start preloads the four carriers to their phase slots and starts them together. Each carrier takes a new duty value only when it wraps, so a running pulse is never cut short. Every main/complementary pair passes through a dead-time stage. The enable input turns all eight gates off in the same cycle it drops.

The duty, period and dead-time words are static control settings sampled every clock. They are not a data stream, so they carry no valid/ready handshake.

Top module: `psm_pwm_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first synchronous start, all eight gate outputs are low.
- R2: When `sync_start` is high at a clock edge with `enable` high, carrier k (k = 0..3) is loaded with floor(k·P/4), where P is `period`. Each carrier then counts up by one per clock and wraps from P−1 to 0. P must be at least 4.
- R3: The command for cell k is high while its carrier value is below its latched duty. A duty of 0 gives no high time, and a duty of P or more gives the full period. `gate_hi[k]` follows the command one clock after the carrier value.
- R4: `gate_lo[k]` is the complement of the cell k command whenever the block is running and no dead time is pending.
- R5: After every change of a cell's command, both of that cell's gates stay low for exactly `dead_time` clocks. A `dead_time` of 0 inserts no gap.
- R6: `gate_hi[k]` and `gate_lo[k]` are never high in the same cycle.
- R7: Each carrier latches `duty` only at a synchronous start and when it wraps from P−1 to 0. A change of `duty` in the middle of a period has no effect on that carrier until its next wrap.
- R8: When `enable` is low, all eight gates are low in that same cycle. The carriers stop, and `sync_start` is ignored. Once `enable` returns high, the gates stay low until a new synchronous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run permission. When low, it forces all gates low at once |
| sync_start | input | 1 | One-cycle pulse that aligns and starts the four carriers |
| period | input | CNT_W | Carrier period P in clock cycles |
| duty | input | CNT_W | Shared duty word in clock cycles |
| dead_time | input | DT_W | Dead-time length in clock cycles |
| gate_hi | output | PAIRS | Main-switch gate per cell |
| gate_lo | output | PAIRS | Complementary-switch gate per cell |

## Verification
Two events can fall in the same cycle: a carrier wrap, where a new duty is latched, and a dead-time interval that is still running on the same cell. To provoke this, the bench changes `duty` in the middle of a period while a non-zero dead time is programmed, so that the next command edge and the duty latch land next to each other.

A second collision happens when `enable` falls on the same edge as a command change. The bench drops `enable` between edges and checks that the gates are low in that same cycle, before any dead-time count could act. Outputs are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic {
    LEG_IDLE = 1'b0,
    LEG_RUN  = 1'b1
  } leg_state_e;
endpackage

// File: rtl/psm_carrier.sv
module psm_carrier #(
  parameter int CNT_W = 10,
  parameter int PAIRS = 4,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_start,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             cmd
);
  localparam int OW = CNT_W + $clog2(PAIRS) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_l;
  logic [OW-1:0]    prod;
  logic [CNT_W-1:0] offset;
  logic             at_end;

  assign prod   = OW'(period) * OW'(IDX);
  assign offset = CNT_W'(prod / OW'(PAIRS));
  assign at_end = (cnt >= (period - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_l <= '0;
    end else if (enable && sync_start) begin
      cnt    <= offset;
      duty_l <= duty;
    end else if (enable && run) begin
      if (at_end) begin
        cnt    <= '0;
        duty_l <= duty;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign cmd = run && (cnt < duty_l);
endmodule

// File: rtl/psm_deadtime.sv
module psm_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            run,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead_time,
  output logic            hi,
  output logic            lo
);
  logic            ref_q;
  logic [DT_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ref_q <= 1'b0;
      gap   <= '0;
    end else begin
      ref_q <= cmd;
      if (cmd != ref_q)
        gap <= dead_time;
      else if (gap != '0)
        gap <= gap - DT_W'(1);
    end
  end

  assign hi = enable && run && ref_q && (gap == '0);
  assign lo = enable && run && !ref_q && (gap == '0);
endmodule

// File: rtl/psm_pwm_gen.sv
module psm_pwm_gen #(
  parameter int CNT_W = 10,
  parameter int DT_W  = 6,
  parameter int PAIRS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_start,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dead_time,
  output logic [PAIRS-1:0] gate_hi,
  output logic [PAIRS-1:0] gate_lo
);
  import psm_pkg::*;

  leg_state_e       state;
  logic             run;
  logic [PAIRS-1:0] cmd;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)
      state <= LEG_IDLE;
    else if (sync_start)
      state <= LEG_RUN;
  end

  assign run = (state == LEG_RUN);

  for (genvar k = 0; k < PAIRS; k++) begin : g_cell
    psm_carrier #(.CNT_W(CNT_W), .PAIRS(PAIRS), .IDX(k)) u_car (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sync_start(sync_start),
      .run(run), .period(period), .duty(duty), .cmd(cmd[k])
    );
    psm_deadtime #(.DT_W(DT_W)) u_dt (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .cmd(cmd[k]),
      .dead_time(dead_time), .hi(gate_hi[k]), .lo(gate_lo[k])
    );
  end
endmodule

// File: rtl/psm_pwm_chk.sv
module psm_pwm_chk #(
  parameter int DT_W  = 6,
  parameter int PAIRS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sync_start,
  input logic [DT_W-1:0]  dead_time,
  input logic [PAIRS-1:0] gate_hi,
  input logic [PAIRS-1:0] gate_lo
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R6

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (gate_hi == '0 && gate_lo == '0)); // R8

  AST_RESTART_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (gate_hi == '0 && gate_lo == '0)); // R8

  for (genvar k = 0; k < PAIRS; k++) begin : g_gap
    AST_GAP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dead_time) != '0 && $fell(gate_hi[k])) |-> !gate_lo[k]); // R5
    AST_GAP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dead_time) != '0 && $fell(gate_lo[k])) |-> !gate_hi[k]); // R5
  end
endmodule

bind psm_pwm_gen psm_pwm_chk #(.DT_W(DT_W), .PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_start(sync_start),
  .dead_time(dead_time), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/sim_psm_pwm_gen.sv
module sim_psm_pwm_gen;
  localparam int CNT_W = 10;
  localparam int DT_W  = 6;
  localparam int PAIRS = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             sync_start = 1'b0;
  logic [CNT_W-1:0] period = 10'd16;
  logic [CNT_W-1:0] duty = '0;
  logic [DT_W-1:0]  dead_time = '0;
  logic [PAIRS-1:0] gate_hi, gate_lo;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  psm_pwm_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .PAIRS(PAIRS)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_start(sync_start),
    .period(period), .duty(duty), .dead_time(dead_time),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // requirement-level model of carriers, latching and dead time
  int m_cnt [PAIRS];
  int m_dl  [PAIRS];
  bit m_ref [PAIRS];
  int m_gap [PAIRS];
  bit m_run = 0;

  task automatic model_edge();
    bit cmd [PAIRS];
    for (int k = 0; k < PAIRS; k++) cmd[k] = m_run && (m_cnt[k] < m_dl[k]);
    if (!rst_n || !enable) begin
      m_run = 0;
      for (int k = 0; k < PAIRS; k++) begin m_ref[k] = 0; m_gap[k] = 0; end
      if (!rst_n)
        for (int k = 0; k < PAIRS; k++) begin m_cnt[k] = 0; m_dl[k] = 0; end
    end else begin
      for (int k = 0; k < PAIRS; k++) begin
        if (sync_start) begin
          m_cnt[k] = (int'(period) * k) / PAIRS;
          m_dl[k]  = int'(duty);
        end else if (m_run) begin
          if (m_cnt[k] >= int'(period) - 1) begin
            m_cnt[k] = 0;
            m_dl[k]  = int'(duty);
          end else m_cnt[k]++;
        end
        if (cmd[k] != m_ref[k]) m_gap[k] = int'(dead_time);
        else if (m_gap[k] > 0) m_gap[k]--;
        m_ref[k] = cmd[k];
      end
      if (sync_start) m_run = 1;
    end
  endtask

  task automatic compare(string tag);
    logic [PAIRS-1:0] eh, el;
    for (int k = 0; k < PAIRS; k++) begin
      eh[k] = enable && m_run && m_ref[k] && (m_gap[k] == 0);
      el[k] = enable && m_run && !m_ref[k] && (m_gap[k] == 0);
    end
    checks++;
    if (gate_hi !== eh || gate_lo !== el) begin
      errors++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, eh, el);
    end
    checks++;
    if ((gate_hi & gate_lo) !== '0) begin
      errors++;
      $display("FAIL R6: hi=%b lo=%b expected no overlap", gate_hi, gate_lo);
    end
  endtask

  // inputs set for the coming edge; advance one clock then compare
  task automatic cyc(string tag);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] dut;
    logic [15:0] dt;
    logic [15:0] len;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd16, 16'd6,  16'd2, 16'd80},
    '{16'd16, 16'd0,  16'd1, 16'd40},
    '{16'd16, 16'd16, 16'd1, 16'd40},
    '{16'd12, 16'd9,  16'd0, 16'd60},
    '{16'd20, 16'd10, 16'd3, 16'd100},
    '{16'd8,  16'd3,  16'd1, 16'd40}
  };

  initial begin
    string vtag [6] = '{"R2/R4/R5", "R3 duty zero", "R3 duty full",
                        "R2/R3 no gap", "R5 long gap", "R4 short period"};
    @(negedge clk);
    compare("R1 in reset");
    enable = 1'b1;
    cyc("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R1 idle after reset");

    for (int v = 0; v < 6; v++) begin
      enable = 1'b0;
      cyc("R8 between vectors");
      enable = 1'b1;
      period = CNT_W'(VECS[v].per);
      duty = CNT_W'(VECS[v].dut);
      dead_time = DT_W'(VECS[v].dt);
      sync_start = 1'b1;
      cyc(vtag[v]);
      sync_start = 1'b0;
      for (int c = 0; c < int'(VECS[v].len); c++) cyc(vtag[v]);
    end

    // R7: duty change mid-period, with a dead time pending near the wrap
    period = 10'd16; duty = 10'd4; dead_time = 6'd2;
    sync_start = 1'b1; cyc("R7 start");
    sync_start = 1'b0;
    for (int c = 0; c < 6; c++) cyc("R7 before change");
    duty = 10'd12;
    for (int c = 0; c < 40; c++) cyc("R7 after change");
    duty = 10'd2;
    for (int c = 0; c < 3; c++) cyc("R7 second change");

    // R8: enable drops between edges; gates must go low at once
    enable = 1'b0;
    #1;
    compare("R8 immediate off");
    checks++;
    if (gate_hi !== '0 || gate_lo !== '0) begin
      errors++;
      $display("FAIL R8: hi=%b lo=%b expected 0 0", gate_hi, gate_lo);
    end
    @(negedge clk);
    sync_start = 1'b1;
    cyc("R8 sync ignored while disabled");
    sync_start = 1'b0;
    enable = 1'b1;
    for (int c = 0; c < 5; c++) cyc("R8 no restart without sync");
    sync_start = 1'b1; cyc("R8 restart");
    sync_start = 1'b0;
    for (int c = 0; c < 20; c++) cyc("R8 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule